// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

The block is a reconfigurable two-level logic plane. A set of product terms each takes the AND of selected literals drawn from the primary inputs and from a small bank of feedback inputs; each output is the OR of the product terms connected to it. The personality (which literal each term uses and which outputs each term reaches) is held in on-chip storage. That storage is loaded one term at a time through a write port that carries a term index, the literal codes for that term and its output connection mask.

A mode input picks between two connection styles. In the unrestricted style any term may feed any output, and one term may feed several outputs at once. In the grouped style each output sees only its own fixed, disjoint slice of terms. The low outputs are also captured every clock into a register that drives the feedback inputs. A function can then be built in two passes, with an intermediate result computed in one cycle and consumed in the next, and no combinational loop can form.

Outputs are combinational in the primary inputs and the feedback register. A personality write takes effect from the clock edge that accepts it.

Top module: `plaArray`

## Requirements
- R1: After reset every literal code and every connection bit is cleared, so every output reads 0 until a term is written.
- R2: Each literal takes a 2-bit code in field bits [2s+1:2s] of the term's literal word, where s is the source index (primary inputs 0..NUM_IN-1, then feedback inputs). Code 00 means the source is not used, 01 uses it true, 10 uses it complemented, and 11 forces the term to 0. A term is the AND of its used literals.
- R3: A term with every literal code at 00 evaluates to 1.
- R4: In unrestricted mode (palMode=0) an output is 1 exactly when at least one term whose connection bit for that output is set evaluates to 1. A term with no connection bits set has no effect on any output.
- R5: One term whose connection mask has several bits set drives all of those outputs at the same time.
- R6: In grouped mode (palMode=1) output o uses only terms o*G to o*G+G-1, where G = NUM_TERM/NUM_OUT (2 by default). Connection bits for that output outside this range are ignored. Changing the mode takes effect with no rewrite.
- R7: With sources D=0, C=1, B=2, A=3 and outputs Z=0, Y=1, X=2, W=3, the personality W=A+BD+BC, X=BC', Y=B+C, Z=A'B'C'D+BCD+AD'+B'CD' maps input codes 0..9 to 0,1,3,2,6,14,10,11,9,8.
- R8: A write with cfgWrEn=1 replaces the literal word and connection mask of term cfgTerm only. The new personality is visible after the accepting clock edge and not before it.
- R9: Every clock, outputs 0..NUM_FB-1 are registered onto feedback sources NUM_IN..NUM_IN+NUM_FB-1. A two-pass function is therefore valid one clock after its inputs change; for example, a full adder built as X=AB'+A'B, Y=AB, then Sum=XCin'+X'Cin, Cout=XCin+Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| palMode | input | 1 | 1 selects grouped term ownership, 0 selects unrestricted connection |
| cfgWrEn | input | 1 | Personality write strobe |
| cfgTerm | input | 4 | Index of the term being written |
| cfgLits | input | 24 | Literal codes, 2 bits per source |
| cfgConn | input | 8 | Output connection mask for the term, bit o feeds output o |
| primIn | input | 8 | Primary inputs |
| outData | output | 8 | Array outputs |

## Verification
The hardest state to reach from the ports is a correct second-pass result, because it depends on the feedback register holding the first-pass values of the same input vector. The stimulus loads a full adder personality, drives each input combination, and compares Sum and Cout only after one clock edge has moved the intermediate terms into feedback. One transition is also sampled before that edge to show the stale intermediate value. Grouped-mode masking is reached by connecting one term to outputs both inside and outside its group, then flipping the mode with the personality left unchanged.

// File: rtl/plaPkg.sv
package plaPkg;

  typedef enum logic [1:0] {
    LIT_FREE  = 2'b00,
    LIT_TRUE  = 2'b01,
    LIT_COMP  = 2'b10,
    LIT_NEVER = 2'b11
  } litCode_e;

  typedef struct packed {
    logic writeTerm;
    logic palSel;
  } plaStrobe_t;

endpackage

// File: rtl/plaCtrl.sv
module plaCtrl
  import plaPkg::*;
#(
  parameter int NUM_TERM = 16,
  parameter int TERM_W   = $clog2(NUM_TERM)
) (
  input  logic              cfgWrEn,
  input  logic [TERM_W-1:0] cfgTerm,
  input  logic              palMode,
  output plaStrobe_t        strobe,
  output logic [NUM_TERM-1:0] termSel
);

  logic idxOk;

  always_comb begin
    idxOk = ({1'b0, cfgTerm} < (TERM_W+1)'(NUM_TERM));
    strobe.writeTerm = cfgWrEn && idxOk;
    strobe.palSel    = palMode;
  end

  for (genvar t = 0; t < NUM_TERM; t++) begin : g_sel
    assign termSel[t] = (cfgTerm == TERM_W'(t));
  end

endmodule

// File: rtl/plaDatapath.sv
module plaDatapath
  import plaPkg::*;
#(
  parameter int NUM_IN   = 8,
  parameter int NUM_FB   = 4,
  parameter int NUM_TERM = 16,
  parameter int NUM_OUT  = 8,
  localparam int NUM_SRC = NUM_IN + NUM_FB,
  localparam int LIT_W   = 2 * NUM_SRC,
  localparam int GROUP   = NUM_TERM / NUM_OUT
) (
  input  logic                clk,
  input  logic                rstN,
  input  plaStrobe_t          strobe,
  input  logic [NUM_TERM-1:0] termSel,
  input  logic [LIT_W-1:0]    cfgLits,
  input  logic [NUM_OUT-1:0]  cfgConn,
  input  logic [NUM_IN-1:0]   primIn,
  output logic [NUM_OUT-1:0]  outData,
  output logic [NUM_TERM-1:0] termHit,
  output logic [NUM_TERM-1:0][NUM_OUT-1:0] connView,
  output logic [NUM_FB-1:0]   fbView
);

  logic [NUM_TERM-1:0][LIT_W-1:0]   litQ;
  logic [NUM_TERM-1:0][NUM_OUT-1:0] connQ;
  logic [NUM_FB-1:0]                fbQ;
  logic [NUM_SRC-1:0]               srcVec;

  assign srcVec   = {fbQ, primIn};
  assign connView = connQ;
  assign fbView   = fbQ;

  // personality storage and term evaluation, one slice per term
  for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        litQ[t]  <= '0;
        connQ[t] <= '0;
      end else if (strobe.writeTerm && termSel[t]) begin
        litQ[t]  <= cfgLits;
        connQ[t] <= cfgConn;
      end
    end

    always_comb begin
      termHit[t] = 1'b1;
      for (int s = 0; s < NUM_SRC; s++) begin
        case (litCode_e'(litQ[t][2*s +: 2]))
          LIT_FREE:  termHit[t] = termHit[t];
          LIT_TRUE:  termHit[t] = termHit[t] & srcVec[s];
          LIT_COMP:  termHit[t] = termHit[t] & ~srcVec[s];
          LIT_NEVER: termHit[t] = 1'b0;
          default:   termHit[t] = 1'b0;
        endcase
      end
    end
  end

  // OR plane with optional group ownership
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [NUM_TERM-1:0] useMask;
    always_comb begin
      for (int t = 0; t < NUM_TERM; t++) begin
        useMask[t] = connQ[t][o] & (!strobe.palSel || ((t / GROUP) == o));
      end
      outData[o] = |(termHit & useMask);
    end
  end

  // feedback register: low outputs return as sources next cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fbQ <= '0;
    else       fbQ <= outData[NUM_FB-1:0];
  end

endmodule

// File: rtl/plaArray.sv
module plaArray
  import plaPkg::*;
#(
  parameter int NUM_IN   = 8,
  parameter int NUM_FB   = 4,
  parameter int NUM_TERM = 16,
  parameter int NUM_OUT  = 8,
  localparam int TERM_W  = $clog2(NUM_TERM),
  localparam int LIT_W   = 2 * (NUM_IN + NUM_FB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              palMode,
  input  logic              cfgWrEn,
  input  logic [TERM_W-1:0] cfgTerm,
  input  logic [LIT_W-1:0]  cfgLits,
  input  logic [NUM_OUT-1:0] cfgConn,
  input  logic [NUM_IN-1:0] primIn,
  output logic [NUM_OUT-1:0] outData
);

  plaStrobe_t                       strobe;
  logic [NUM_TERM-1:0]              termSel;
  logic [NUM_TERM-1:0]              termHit;
  logic [NUM_TERM-1:0][NUM_OUT-1:0] connView;
  logic [NUM_FB-1:0]                fbView;

  plaCtrl #(.NUM_TERM(NUM_TERM)) u_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgTerm (cfgTerm),
    .palMode (palMode),
    .strobe  (strobe),
    .termSel (termSel)
  );

  plaDatapath #(
    .NUM_IN(NUM_IN), .NUM_FB(NUM_FB), .NUM_TERM(NUM_TERM), .NUM_OUT(NUM_OUT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .termSel  (termSel),
    .cfgLits  (cfgLits),
    .cfgConn  (cfgConn),
    .primIn   (primIn),
    .outData  (outData),
    .termHit  (termHit),
    .connView (connView),
    .fbView   (fbView)
  );

endmodule

// File: rtl/plaArrayChecker.sv
module plaArrayChecker #(
  parameter int NUM_FB   = 4,
  parameter int NUM_TERM = 16,
  parameter int NUM_OUT  = 8,
  localparam int GROUP   = NUM_TERM / NUM_OUT
) (
  input logic                clk,
  input logic                rstN,
  input logic                palMode,
  input logic                cfgWrEn,
  input logic [NUM_OUT-1:0]  outData,
  input logic [NUM_TERM-1:0] termHit,
  input logic [NUM_TERM-1:0][NUM_OUT-1:0] connView,
  input logic [NUM_FB-1:0]   fbView
);

  logic written;
  logic pastOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      written <= 1'b0;
      pastOk  <= 1'b0;
    end else begin
      if (cfgWrEn) written <= 1'b1;
      pastOk <= 1'b1;
    end
  end

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rstN)
    !written |-> (outData == '0));

  a_r9_fb_delay: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> (fbView == $past(outData[NUM_FB-1:0])));

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
    logic anyLive;
    logic grpLive;
    always_comb begin
      anyLive = 1'b0;
      grpLive = 1'b0;
      for (int t = 0; t < NUM_TERM; t++) begin
        if (termHit[t] && connView[t][o]) begin
          anyLive = 1'b1;
          if (t >= o * GROUP && t < (o + 1) * GROUP) grpLive = 1'b1;
        end
      end
    end

    a_r4_or_plane: assert property (@(posedge clk) disable iff (!rstN)
      !palMode |-> (outData[o] == anyLive));

    a_r6_pal_group: assert property (@(posedge clk) disable iff (!rstN)
      palMode |-> (outData[o] == grpLive));
  end

endmodule

bind plaArray plaArrayChecker #(
  .NUM_FB(NUM_FB), .NUM_TERM(NUM_TERM), .NUM_OUT(NUM_OUT)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .palMode  (palMode),
  .cfgWrEn  (cfgWrEn),
  .outData  (outData),
  .termHit  (termHit),
  .connView (connView),
  .fbView   (fbView)
);

// File: tb/plaArray_bench.sv
`timescale 1ns/1ps
module plaArray_bench;

  localparam int NTERM = 16;
  localparam int LW    = 24;
  localparam logic [1:0] FR = 2'b00, TR = 2'b01, CP = 2'b10, NV = 2'b11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        palMode = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgTerm = '0;
  logic [LW-1:0] cfgLits = '0;
  logic [7:0]  cfgConn = '0;
  logic [7:0]  primIn = '0;
  logic [7:0]  outData;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  plaArray u_plaArray (
    .clk(clk), .rstN(rstN), .palMode(palMode), .cfgWrEn(cfgWrEn),
    .cfgTerm(cfgTerm), .cfgLits(cfgLits), .cfgConn(cfgConn),
    .primIn(primIn), .outData(outData)
  );

  function automatic logic [LW-1:0] lit(int src, logic [1:0] code);
    return LW'(code) << (2 * src);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeTerm(int idx, logic [LW-1:0] lits, logic [7:0] conn);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgTerm = 4'(idx); cfgLits = lits; cfgConn = conn;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic clearAll();
    for (int t = 0; t < NTERM; t++) writeTerm(t, '0, '0);
  endtask

  task automatic drive(logic [7:0] v);
    @(negedge clk);
    primIn = v;
    #1;
  endtask

  task automatic testReset();
    drive(8'h00); chk("R1 reset zeros", outData, 8'h00);
    drive(8'hff); chk("R1 reset zeros", outData, 8'h00);
  endtask

  task automatic testLiterals();
    // term0 = src0 & ~src1 -> out0
    writeTerm(0, lit(0, TR) | lit(1, CP), 8'h01);
    drive(8'h01); chk("R2 true/comp hit", outData, 8'h01);
    drive(8'h03); chk("R2 comp blocks", outData, 8'h00);
    drive(8'h00); chk("R2 true blocks", outData, 8'h00);
    // never code on src2 kills the term
    writeTerm(0, lit(0, TR) | lit(2, NV), 8'h01);
    drive(8'h05); chk("R2 never code", outData, 8'h00);
    drive(8'h01); chk("R2 never code", outData, 8'h00);
    clearAll();
  endtask

  task automatic testEmptyTerm();
    writeTerm(1, '0, 8'h02);
    drive(8'h00); chk("R3 empty term", outData, 8'h02);
    drive(8'ha5); chk("R3 empty term", outData, 8'h02);
    clearAll();
  endtask

  task automatic testOrShare();
    writeTerm(2, lit(0, TR), 8'h24);   // out2 and out5
    writeTerm(3, lit(1, TR), 8'h04);   // out2
    writeTerm(4, lit(2, TR), 8'h00);   // unconnected
    for (int v = 0; v < 8; v++) begin
      logic [7:0] e;
      e = '0;
      e[2] = v[0] | v[1];
      e[5] = v[0];
      drive(8'(v));
      chk("R4 R5 or plane / sharing", outData, e);
    end
    clearAll();
  endtask

  task automatic testPal();
    writeTerm(0, '0, 8'h03);           // group of out0, also asks for out1
    writeTerm(3, lit(0, TR), 8'h03);   // group of out1, also asks for out0
    palMode = 1'b0;
    drive(8'h00); chk("R6 unrestricted", outData, 8'h03);
    palMode = 1'b1;
    drive(8'h00); chk("R6 grouped masks", outData, 8'h01);
    drive(8'h01); chk("R6 grouped own term", outData, 8'h03);
    writeTerm(0, lit(0, CP), 8'h03);
    drive(8'h01); chk("R6 foreign term ignored", outData, 8'h02);
    palMode = 1'b0;
    drive(8'h01); chk("R6 mode back", outData, 8'h03);
    clearAll();
  endtask

  task automatic testGray();
    logic [3:0] exp [10] = '{4'd0, 4'd1, 4'd3, 4'd2, 4'd6, 4'd14, 4'd10, 4'd11, 4'd9, 4'd8};
    // D=0 C=1 B=2 A=3 ; Z=0 Y=1 X=2 W=3
    writeTerm(0, lit(3, TR), 8'h08);
    writeTerm(1, lit(2, TR) | lit(0, TR), 8'h08);
    writeTerm(2, lit(2, TR) | lit(1, TR), 8'h08);
    writeTerm(3, lit(2, TR) | lit(1, CP), 8'h04);
    writeTerm(4, lit(2, TR), 8'h02);
    writeTerm(5, lit(1, TR), 8'h02);
    writeTerm(6, lit(3, CP) | lit(2, CP) | lit(1, CP) | lit(0, TR), 8'h01);
    writeTerm(7, lit(2, TR) | lit(1, TR) | lit(0, TR), 8'h01);
    writeTerm(8, lit(3, TR) | lit(0, CP), 8'h01);
    writeTerm(9, lit(2, CP) | lit(1, TR) | lit(0, CP), 8'h01);
    for (int v = 0; v < 10; v++) begin
      drive(8'(v));
      chk("R7 code converter", outData, {4'h0, exp[v]});
    end
    clearAll();
  endtask

  task automatic testWrite();
    writeTerm(5, '0, 8'h10);
    drive(8'h00); chk("R8 write visible", outData, 8'h10);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgTerm = 4'd5; cfgLits = '0; cfgConn = 8'h40;
    #1; chk("R8 not before edge", outData, 8'h10);
    @(negedge clk);
    cfgWrEn = 1'b0;
    #1; chk("R8 replaced after edge", outData, 8'h40);
    clearAll();
  endtask

  task automatic testAdder();
    // A=src0 B=src1 Cin=src2 ; X=out0 Y=out1 Sum=out2 Cout=out3 ; X fb=src8 Y fb=src9
    writeTerm(0, lit(0, TR) | lit(1, CP), 8'h01);
    writeTerm(1, lit(0, CP) | lit(1, TR), 8'h01);
    writeTerm(2, lit(0, TR) | lit(1, TR), 8'h02);
    writeTerm(3, lit(8, TR) | lit(2, CP), 8'h04);
    writeTerm(4, lit(8, CP) | lit(2, TR), 8'h04);
    writeTerm(5, lit(8, TR) | lit(2, TR), 8'h08);
    writeTerm(6, lit(9, TR), 8'h08);
    drive(8'h00);
    @(negedge clk);
    primIn = 8'h01; #1;
    chk("R9 stale before edge", {7'b0, outData[2]}, 8'h00);
    @(negedge clk); #1;
    chk("R9 sum after edge", {7'b0, outData[2]}, 8'h01);
    for (int v = 0; v < 8; v++) begin
      int s;
      s = v[0] + v[1] + v[2];
      drive(8'(v));
      @(negedge clk); #1;
      chk("R9 full adder", {6'b0, outData[3], outData[2]}, 8'(s));
    end
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLiterals();
    testEmptyTerm();
    testOrShare();
    testPal();
    testGray();
    testWrite();
    testAdder();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule